// File: doc/BRIEF.md
# Shared-Buffer IN Endpoint Responder

This block chooses how a USB device answers a host IN token that targets one of two interrupt endpoints. Both endpoints draw on a single eight-byte transmit buffer. A local configuration register holds four fields: a data-toggle bit, an endpoint-select bit that gives the buffer to one endpoint, a transmit-enable bit and a four-bit payload size. Per-endpoint enable and stall levels arrive from elsewhere in the device. A transmit-done flag records that a packet went out.

Tokens arrive already decoded, as an endpoint number with a one-cycle strobe. One cycle later the block presents a registered decision: data (DATA0 or DATA1 PID and a byte count), NAK, STALL or silence. Serialization, CRC and line coding happen downstream. When data is issued, the block sets the done flag and clears transmit-enable. Later tokens then receive NAK until the CPU side rearms the endpoint. Hardware never advances the data toggle. Firmware owns that bit.

Top module: `in_ep_responder`

## Requirements
- R1: After reset the configuration readback `cfg_o` is 0, `done_o` is 0 and `rsp_vld_o` is 0.
- R2: `rsp_vld_o` is high exactly in the cycle after a cycle with `tok_vld_i` high, and low otherwise.
- R3: A data decision is coded `rsp_kind_o`=1. Its PID bit equals the toggle field `cfg[6]` (1 = DATA1, 0 = DATA0). For every other decision, `rsp_pid_o` and `rsp_len_o` are 0.
- R4: The toggle field `cfg[6]` changes only on a CPU write (`cfg_we_i`), including after data is sent.
- R5: The select field `cfg[5]` assigns the buffer to endpoint 2 when 1 and to endpoint 1 when 0. An enabled, unstalled and armed endpoint that is not selected gets NAK (code 2).
- R6: An enabled, unstalled endpoint gets NAK when transmit-enable `cfg[4]` is 0 or `done_o` is 1.
- R7: An enabled endpoint whose stall input is set gets STALL (code 3), whatever the other conditions are.
- R8: A token to a disabled endpoint, or to an endpoint number other than 1 or 2, gets no response (code 0). Endpoint 1 uses bit 0 of `ep_en_i` and `ep_stall_i`. Endpoint 2 uses bit 1.
- R9: The data length equals the size field `cfg[3:0]`, clamped to 8.
- R10: Issuing data sets `done_o` and clears `cfg[4]` at the same edge. `done_clr_i` clears `done_o`. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 7 | Write data: {toggle, select, tx_en, size[3:0]} |
| cfg_o | output | 7 | Configuration readback, same layout |
| done_clr_i | input | 1 | Clears the transmit-done flag |
| done_o | output | 1 | Transmit-done flag |
| ep_en_i | input | 2 | Endpoint enables, bit 0 = endpoint 1 |
| ep_stall_i | input | 2 | Endpoint stalls, bit 0 = endpoint 1 |
| tok_vld_i | input | 1 | IN token strobe |
| tok_ep_i | input | 4 | Endpoint number of the token |
| rsp_vld_o | output | 1 | Decision valid |
| rsp_kind_o | output | 2 | 0 none, 1 data, 2 NAK, 3 STALL |
| rsp_pid_o | output | 1 | 1 = DATA1, 0 = DATA0 |
| rsp_len_o | output | 4 | Data byte count |

## Verification
The assertions assume that the endpoint enable and stall levels, and the configuration, are steady in the cycle a token is presented. They also assume tokens are single-cycle strobes. The stimulus changes configuration, enables and stalls only in cycles without a token strobe. It then holds them steady while the token is applied, so each decision depends only on settled state. The only deliberate overlap is a done-flag clear issued in the same cycle as a token, which exercises the set-over-clear priority.

// File: rtl/in_resp_pkg.sv
package in_resp_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DATA  = 2'd1,
    RSP_NAK   = 2'd2,
    RSP_STALL = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/in_resp_cfg.sv
module in_resp_cfg #(
  parameter int LEN_W = 4,
  parameter int SEL_W = 1,
  localparam int CFG_W = LEN_W + SEL_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             tx_clr_i,
  output logic             tog_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             tx_en_o,
  output logic [LEN_W-1:0] size_o
);
  logic             tog_q, tx_q;
  logic [SEL_W-1:0] sel_q;
  logic [LEN_W-1:0] size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      sel_q  <= '0;
      tx_q   <= 1'b0;
      size_q <= '0;
    end else begin
      if (we_i) begin
        tog_q  <= wdata_i[CFG_W-1];
        sel_q  <= wdata_i[LEN_W+1 +: SEL_W];
        size_q <= wdata_i[LEN_W-1:0];
      end
      // hardware disarm wins over a same-cycle write
      if (tx_clr_i)  tx_q <= 1'b0;
      else if (we_i) tx_q <= wdata_i[LEN_W];
    end
  end

  assign tog_o   = tog_q;
  assign sel_o   = sel_q;
  assign tx_en_o = tx_q;
  assign size_o  = size_q;

  p_tog_sw_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(tog_q));
  p_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr_i |=> !tx_q);
endmodule

// File: rtl/in_resp_decide.sv
module in_resp_decide
  import in_resp_pkg::*;
#(
  parameter int NUM_EP    = 2,
  parameter int EP_W      = 4,
  parameter int LEN_W     = 4,
  parameter int SEL_W     = 1,
  parameter int BUF_BYTES = 8
) (
  input  logic [EP_W-1:0]   tok_ep_i,
  input  logic              tog_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              tx_en_i,
  input  logic [LEN_W-1:0]  size_i,
  input  logic              done_i,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic [NUM_EP-1:0] ep_stall_i,
  output rsp_kind_e         kind_o,
  output logic              pid_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BYTES);

  logic      [NUM_EP-1:0] ep_hit;
  rsp_kind_e              ep_kind [NUM_EP];

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign ep_hit[i] = (tok_ep_i == EP_W'(i + 1));
    always_comb begin
      if (!ep_en_i[i])                                     ep_kind[i] = RSP_NONE;
      else if (ep_stall_i[i])                              ep_kind[i] = RSP_STALL;
      else if (done_i || !tx_en_i || sel_i != SEL_W'(i))   ep_kind[i] = RSP_NAK;
      else                                                 ep_kind[i] = RSP_DATA;
    end
  end

  always_comb begin
    kind_o = RSP_NONE;
    for (int i = 0; i < NUM_EP; i++)
      if (ep_hit[i]) kind_o = ep_kind[i];
  end

  assign pid_o = (kind_o == RSP_DATA) && tog_i;
  assign len_o = (kind_o != RSP_DATA) ? '0 :
                 (size_i > MAX_LEN)   ? MAX_LEN : size_i;

  always_comb begin
    a_len_cap_r9: assert (len_o <= MAX_LEN);
  end
endmodule

// File: rtl/in_ep_responder.sv
module in_ep_responder
  import in_resp_pkg::*;
#(
  parameter int NUM_EP    = 2,
  parameter int EP_W      = 4,
  parameter int LEN_W     = 4,
  parameter int BUF_BYTES = 8,
  localparam int SEL_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int CFG_W    = LEN_W + SEL_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_o,
  input  logic              done_clr_i,
  output logic              done_o,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic [NUM_EP-1:0] ep_stall_i,
  input  logic              tok_vld_i,
  input  logic [EP_W-1:0]   tok_ep_i,
  output logic              rsp_vld_o,
  output logic [1:0]        rsp_kind_o,
  output logic              rsp_pid_o,
  output logic [LEN_W-1:0]  rsp_len_o
);
  logic             tog, tx_en, send;
  logic [SEL_W-1:0] sel;
  logic [LEN_W-1:0] size, d_len, len_q;
  rsp_kind_e        d_kind, kind_q;
  logic             d_pid, pid_q, vld_q, done_q;

  in_resp_cfg #(.LEN_W(LEN_W), .SEL_W(SEL_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .tx_clr_i(send),
    .tog_o(tog), .sel_o(sel), .tx_en_o(tx_en), .size_o(size)
  );

  in_resp_decide #(
    .NUM_EP(NUM_EP), .EP_W(EP_W), .LEN_W(LEN_W),
    .SEL_W(SEL_W), .BUF_BYTES(BUF_BYTES)
  ) u_dec (
    .tok_ep_i, .tog_i(tog), .sel_i(sel), .tx_en_i(tx_en), .size_i(size),
    .done_i(done_q), .ep_en_i, .ep_stall_i,
    .kind_o(d_kind), .pid_o(d_pid), .len_o(d_len)
  );

  assign send = tok_vld_i && (d_kind == RSP_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      kind_q <= RSP_NONE;
      pid_q  <= 1'b0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q <= tok_vld_i;
      if (tok_vld_i) begin
        kind_q <= d_kind;
        pid_q  <= d_pid;
        len_q  <= d_len;
      end
      if (send)            done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign cfg_o      = {tog, sel, tx_en, size};
  assign done_o     = done_q;
  assign rsp_vld_o  = vld_q;
  assign rsp_kind_o = kind_q;
  assign rsp_pid_o  = pid_q;
  assign rsp_len_o  = len_q;

  p_one_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_vld_i |=> rsp_vld_o);
  p_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_vld_i |=> !rsp_vld_o);
  p_stall_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && tok_ep_i == EP_W'(1) && ep_en_i[0] && ep_stall_i[0])
    |=> rsp_kind_o == 2'(RSP_STALL));
  p_wrong_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && tok_ep_i == EP_W'(2) && ep_en_i[1] && !ep_stall_i[1]
     && tx_en && !done_q && sel == '0)
    |=> rsp_kind_o == 2'(RSP_NAK));
  p_data_arms_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_vld_o && rsp_kind_o == 2'(RSP_DATA)) |-> (done_o && !tx_en));
  p_toggle_pid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && d_kind == RSP_DATA) |=> rsp_pid_o == $past(tog));
endmodule

// File: tb/sim_in_ep_responder.sv
`timescale 1ns/1ps
module sim_in_ep_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, done_clr = 1'b0, tok_vld = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [1:0] ep_en = '0, ep_stall = '0;
  logic [3:0] tok_ep = '0;
  logic [6:0] cfg_rd;
  logic       done, rsp_vld, rsp_pid;
  logic [1:0] rsp_kind;
  logic [3:0] rsp_len;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  in_ep_responder u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd),
    .done_clr_i(done_clr), .done_o(done),
    .ep_en_i(ep_en), .ep_stall_i(ep_stall),
    .tok_vld_i(tok_vld), .tok_ep_i(tok_ep),
    .rsp_vld_o(rsp_vld), .rsp_kind_o(rsp_kind),
    .rsp_pid_o(rsp_pid), .rsp_len_o(rsp_len)
  );

  // {cfg[6:0], en[1:0], stall[1:0], ep[3:0], kind[1:0], pid, len[3:0]}
  localparam logic [21:0] VEC [14] = '{
    {7'h14, 2'b01, 2'b00, 4'd1, 2'd1, 1'b0, 4'd4},  // R3 ep1 DATA0
    {7'h78, 2'b10, 2'b00, 4'd2, 2'd1, 1'b1, 4'd8},  // R3 ep2 DATA1
    {7'h1C, 2'b01, 2'b00, 4'd1, 2'd1, 1'b0, 4'd8},  // R9 clamp 12->8
    {7'h14, 2'b10, 2'b00, 4'd2, 2'd2, 1'b0, 4'd0},  // R5 ep2, sel=ep1
    {7'h34, 2'b01, 2'b00, 4'd1, 2'd2, 1'b0, 4'd0},  // R5 ep1, sel=ep2
    {7'h04, 2'b01, 2'b00, 4'd1, 2'd2, 1'b0, 4'd0},  // R6 tx_en off
    {7'h14, 2'b01, 2'b01, 4'd1, 2'd3, 1'b0, 4'd0},  // R7 ep1 stall
    {7'h34, 2'b10, 2'b10, 4'd2, 2'd3, 1'b0, 4'd0},  // R7 ep2 stall
    {7'h14, 2'b00, 2'b00, 4'd1, 2'd0, 1'b0, 4'd0},  // R8 disabled
    {7'h14, 2'b11, 2'b00, 4'd3, 2'd0, 1'b0, 4'd0},  // R8 ep3
    {7'h14, 2'b11, 2'b01, 4'd0, 2'd0, 1'b0, 4'd0},  // R8 ep0
    {7'h50, 2'b01, 2'b00, 4'd1, 2'd1, 1'b1, 4'd0},  // R9 zero length
    {7'h34, 2'b10, 2'b01, 4'd2, 2'd1, 1'b0, 4'd4},  // R7 other ep stall
    {7'h14, 2'b00, 2'b01, 4'd1, 2'd0, 1'b0, 4'd0}   // R8 disabled+stall
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [6:0] v, input logic clr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v; done_clr = clr;
    @(negedge clk);
    cfg_we = 1'b0; done_clr = 1'b0;
  endtask

  task automatic token(input logic [3:0] ep, input logic clr);
    @(negedge clk);
    tok_vld = 1'b1; tok_ep = ep; done_clr = clr;
    @(negedge clk);
    tok_vld = 1'b0; done_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    #9;
    check("R1 cfg", 32'(cfg_rd), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    check("R1 vld", 32'(rsp_vld), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < 14; i++) begin
      wr_cfg(VEC[i][21:15], 1'b1);
      ep_en = VEC[i][14:13]; ep_stall = VEC[i][12:11];
      token(VEC[i][10:7], 1'b0);
      check($sformatf("R3/R5-R9 vec%0d", i),
            32'({rsp_vld, rsp_kind, rsp_pid, rsp_len}),
            32'({1'b1, VEC[i][6:0]}));
      @(negedge clk);
      check($sformatf("R2 vec%0d", i), 32'(rsp_vld), 32'h0);
    end

    // R10 / R4: data sent disarms, toggle unchanged, then NAK
    wr_cfg(7'h74, 1'b1);
    ep_en = 2'b10; ep_stall = 2'b00;
    token(4'd2, 1'b0);
    check("R3 armed data", 32'({rsp_kind, rsp_pid, rsp_len}), 32'({2'd1, 1'b1, 4'd4}));
    check("R10 done set", 32'(done), 32'h1);
    check("R10 tx_en cleared / R4 toggle kept", 32'(cfg_rd), 32'h64);
    token(4'd2, 1'b0);
    check("R6 nak after send", 32'(rsp_kind), 32'h2);
    // R6: rearm tx_en only, done still set -> NAK
    wr_cfg(7'h74, 1'b0);
    token(4'd2, 1'b0);
    check("R6 nak while done", 32'(rsp_kind), 32'h2);
    check("R4 toggle after nak", 32'(cfg_rd[6]), 32'h1);
    // R10 clear then set-wins
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    check("R10 done cleared", 32'(done), 32'h0);
    token(4'd2, 1'b1);
    check("R10 set wins over clear", 32'(done), 32'h1);
    check("R3 data before set", 32'(rsp_kind), 32'h1);
    // R2 back-to-back tokens
    @(negedge clk); tok_vld = 1'b1; tok_ep = 4'd3;
    @(negedge clk); tok_vld = 1'b1; tok_ep = 4'd1;
    check("R2 b2b first", 32'({rsp_vld, rsp_kind}), 32'({1'b1, 2'd0}));
    @(negedge clk); tok_vld = 1'b0;
    check("R8 b2b ep1 disabled", 32'({rsp_vld, rsp_kind}), 32'({1'b1, 2'd0}));
    finish_run();
  end
endmodule